// File: doc/BRIEF.md
# Digital correlated double sampler

This block turns a stream of 12-bit ADC samples of CCD video into one pixel value per pixel period, using a differential averager. An external readout sequencer drives four plain strobes. A clear strobe starts a new pixel. A take strobe marks the samples to integrate. A direction input chooses whether a sample is added, during the reference pedestal, or subtracted, during the signal pedestal. A transmit strobe hands the finished pixel on. Because reference samples count positive and signal samples count negative, a negative-going charge step gives a positive pixel value.

The 20-bit signed sum is cut down to a 16-bit word by an arithmetic right shift of 0 to 4 places, with saturation to the signed 16-bit range. The word then goes into an output FIFO. A raw mode skips the integration and writes every valid ADC sample, zero-extended, into the same FIFO, so that the noise spectrum of the sensor can be recorded.

The input sample stream comes from a free-running converter and cannot be stalled, so it has a valid qualifier and no ready. The output side is a valid/ready stream. A word leaves the FIFO only in a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the word on the output stays put. Back-pressure never reaches the input side. A write that finds the FIFO full is lost and raises a sticky overflow flag.

Top module: `dcds_core`

## Requirements
- R1: After reset `out_valid` and `ovf_flag` are low and the accumulator holds zero, so a transmit strobe straight after reset stores the word 0.
- R2: In a cycle with `acc_take` and `smp_valid` high, the zero-extended sample is added to the 20-bit accumulator when `acc_add`=1 and subtracted when `acc_add`=0. The sum wraps modulo 2^20.
- R3: `acc_clear` starts a new pixel. The accumulator becomes zero, or becomes just that cycle's signed sample when a sample is also taken in the same cycle.
- R4: A sample with `acc_take` low, or with `smp_valid` low, leaves the accumulator unchanged.
- R5: In processed mode (`raw_mode`=0), `pix_xmit` writes one word built from the accumulator as it stood before that cycle's update.
- R6: The written word is the signed 20-bit sum arithmetically shifted right by `scale_sel` places (values 5 to 7 act as 4), then clamped to the range -32768 to 32767.
- R7: In raw mode (`raw_mode`=1), every sample with `smp_valid` high is written as {4'b0000, sample}, and `pix_xmit` has no effect.
- R8: Words leave in write order. A written word shows at the output in the next cycle. A word is removed only when `out_valid`&`out_ready`, and while `out_ready` is low the output word is held.
- R9: A write that arrives while the FIFO holds 2^FIFO_AW words is dropped and sets `ovf_flag`, even if a word is read out in the same cycle.
- R10: `ovf_flag` stays high until `ovf_clr` is asserted. If a dropped write and `ovf_clr` fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | ADC sample present this cycle |
| smp_data | input | 12 | Unsigned ADC sample |
| acc_clear | input | 1 | Start a new pixel |
| acc_take | input | 1 | Integrate the current sample |
| acc_add | input | 1 | 1 adds the sample, 0 subtracts it |
| pix_xmit | input | 1 | Write the current pixel to the FIFO |
| raw_mode | input | 1 | 1 writes raw samples instead of pixels |
| scale_sel | input | 3 | Right-shift amount, 0 to 4 |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Oldest FIFO word |
| ovf_flag | output | 1 | Sticky flag for a dropped write |
| ovf_clr | input | 1 | Clear the overflow flag |

## Verification
The bench builds the block with `FIFO_AW`=3, an 8-entry FIFO, so filling, a write dropped into a full FIFO, and a read and a dropped write in the same cycle all happen within a few dozen cycles. The sample and accumulator widths keep their default values. Around a hundred full-scale samples therefore push the sum past the 16-bit range, and the saturation corners can be reached on both signs. With the same widths, the largest shift still leaves a value inside the 16-bit range, which exposes the clamp of `scale_sel` values above 4.

// File: rtl/dcds_pkg.sv
package dcds_pkg;
  typedef enum logic {
    SRC_PIXEL = 1'b0,
    SRC_RAW   = 1'b1
  } src_e;

  typedef enum logic {
    DIR_SUB = 1'b0,
    DIR_ADD = 1'b1
  } dir_e;
endpackage

// File: rtl/dcds_accum.sv
module dcds_accum #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    take,
  input  dcds_pkg::dir_e          dir,
  input  logic [SMP_W-1:0]        sample,
  output logic signed [ACC_W-1:0] acc
);
  localparam int PAD_W = ACC_W - SMP_W;

  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] delta;
  logic signed [ACC_W-1:0] base;

  always_comb begin
    ext   = {{PAD_W{1'b0}}, sample};
    delta = (dir == dcds_pkg::DIR_ADD) ? ext : -ext;
    base  = clear ? '0 : acc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clear || take) begin
      acc <= take ? base + delta : base;
    end
  end
endmodule

// File: rtl/dcds_scaler.sv
module dcds_scaler #(
  parameter int ACC_W  = 20,
  parameter int OUT_W  = 16,
  parameter int SH_W   = 3,
  parameter int MAX_SH = 4
) (
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic [SH_W-1:0]         shift_sel,
  output logic [OUT_W-1:0]        word
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

  logic [SH_W-1:0]         sh_eff;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    sh_eff  = (shift_sel > SH_W'(MAX_SH)) ? SH_W'(MAX_SH) : shift_sel;
    shifted = acc_in >>> sh_eff;
  end

  generate
    if (ACC_W > OUT_W) begin : g_sat
      always_comb begin
        if (shifted > HI)      word = HI[OUT_W-1:0];
        else if (shifted < LO) word = LO[OUT_W-1:0];
        else                   word = shifted[OUT_W-1:0];
      end
    end else begin : g_ext
      always_comb word = OUT_W'(shifted);
    end
  endgenerate
endmodule

// File: rtl/dcds_fifo.sv
module dcds_fifo #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          push;
  logic          pop;

  always_comb begin
    full     = (level == (AW+1)'(DEPTH));
    rd_valid = (level != '0);
    push     = wr_en && !full;
    pop      = rd_valid && rd_ready;
    rd_data  = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/dcds_core.sv
module dcds_core #(
  parameter int SMP_W     = 12,
  parameter int ACC_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SH_W      = 3,
  parameter int MAX_SHIFT = 4,
  parameter int FIFO_AW   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             acc_clear,
  input  logic             acc_take,
  input  logic             acc_add,
  input  logic             pix_xmit,
  input  logic             raw_mode,
  input  logic [SH_W-1:0]  scale_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             ovf_flag,
  input  logic             ovf_clr
);
  import dcds_pkg::*;

  localparam int RAW_PAD = OUT_W - SMP_W;

  src_e                    src;
  dir_e                    dir;
  logic                    take_q;
  logic signed [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0]        scaled;
  logic                    wr_req;
  logic [OUT_W-1:0]        wr_data;
  logic                    fifo_full;
  logic [FIFO_AW:0]        fifo_level;

  always_comb begin
    src    = raw_mode ? SRC_RAW : SRC_PIXEL;
    dir    = acc_add ? DIR_ADD : DIR_SUB;
    take_q = acc_take && smp_valid;
  end

  dcds_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (acc_clear),
    .take   (take_q),
    .dir    (dir),
    .sample (smp_data),
    .acc    (acc_q)
  );

  dcds_scaler #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W), .MAX_SH(MAX_SHIFT)) u_scale (
    .acc_in    (acc_q),
    .shift_sel (scale_sel),
    .word      (scaled)
  );

  always_comb begin
    if (src == SRC_RAW) begin
      wr_req  = smp_valid;
      wr_data = {{RAW_PAD{1'b0}}, smp_data};
    end else begin
      wr_req  = pix_xmit;
      wr_data = scaled;
    end
  end

  dcds_fifo #(.DW(OUT_W), .AW(FIFO_AW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_req),
    .wr_data  (wr_data),
    .full     (fifo_full),
    .rd_valid (out_valid),
    .rd_ready (out_ready),
    .rd_data  (out_data),
    .level    (fifo_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    ovf_flag <= 1'b0;
    else if (wr_req && fifo_full)  ovf_flag <= 1'b1;
    else if (ovf_clr)              ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/dcds_core_chk.sv
module dcds_core_chk #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 20,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic                    acc_clear,
  input logic                    acc_take,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [OUT_W-1:0]        out_data,
  input logic                    ovf_flag,
  input logic                    ovf_clr,
  input logic signed [ACC_W-1:0] acc_q,
  input logic                    wr_req,
  input logic                    fifo_full
);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_drop_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fifo_full) |=> ovf_flag);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(wr_req && fifo_full)) |=> !ovf_flag);

  assert_acc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clear && !(acc_take && smp_valid)) |=> $stable(acc_q));

  assert_acc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clear && !(acc_take && smp_valid)) |=> (acc_q == '0));
endmodule

bind dcds_core dcds_core_chk #(.SMP_W(SMP_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .acc_clear (acc_clear),
  .acc_take  (acc_take),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .ovf_flag  (ovf_flag),
  .ovf_clr   (ovf_clr),
  .acc_q     (acc_q),
  .wr_req    (wr_req),
  .fifo_full (fifo_full)
);

// File: tb/test_dcds_core.sv
module test_dcds_core;
  localparam int AW    = 3;
  localparam int DEPTH = 2 ** AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        acc_clear = 1'b0;
  logic        acc_take = 1'b0;
  logic        acc_add = 1'b0;
  logic        pix_xmit = 1'b0;
  logic        raw_mode = 1'b0;
  logic [2:0]  scale_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        ovf_flag;
  logic        ovf_clr = 1'b0;

  always #2.5 clk = ~clk;

  dcds_core #(.FIFO_AW(AW)) i_dcds_core (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .acc_clear(acc_clear), .acc_take(acc_take), .acc_add(acc_add),
    .pix_xmit(pix_xmit), .raw_mode(raw_mode), .scale_sel(scale_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  int          checks = 0;
  int          errors = 0;
  string       tag = "R1";
  logic [19:0] m_acc = '0;
  logic        m_ovf = 1'b0;
  logic [15:0] mq[$];
  bit          done = 1'b0;

  function automatic logic [15:0] exp_scale(logic [19:0] a, logic [2:0] s);
    int v;
    int sh;
    v  = $signed({{12{a[19]}}, a});
    sh = (s > 3'd4) ? 4 : int'(s);
    v  = v >>> sh;
    if (v > 32767)  v = 32767;
    if (v < -32768) v = -32768;
    return v[15:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    smp_valid = 0; acc_clear = 0; acc_take = 0; pix_xmit = 0; ovf_clr = 0;
  endtask

  // apply current inputs for one clock, update the model, compare at the next falling edge
  task automatic tick();
    bit          pop;
    bit          full;
    bit          wr;
    logic [15:0] wd;
    logic [19:0] nxt;
    pop  = (mq.size() != 0) && out_ready;
    full = (mq.size() == DEPTH);
    if (raw_mode) begin
      wr = smp_valid; wd = {4'b0000, smp_data};
    end else begin
      wr = pix_xmit;  wd = exp_scale(m_acc, scale_sel);
    end
    nxt = acc_clear ? 20'd0 : m_acc;
    if (acc_take && smp_valid) nxt = acc_add ? nxt + {8'd0, smp_data} : nxt - {8'd0, smp_data};
    m_acc = nxt;
    if (pop) void'(mq.pop_front());
    if (wr && !full) mq.push_back(wd);
    if (wr && full) m_ovf = 1'b1;
    else if (ovf_clr) m_ovf = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " out_valid"}, 32'(out_valid), 32'(mq.size() != 0));
    if (mq.size() != 0) check({tag, " out_data"}, 32'(out_data), 32'(mq[0]));
    check({tag, " ovf_flag"}, 32'(ovf_flag), 32'(m_ovf));
  endtask

  task automatic take(logic add, logic [11:0] d, logic clr);
    idle(); smp_valid = 1; acc_take = 1; acc_add = add; smp_data = d; acc_clear = clr;
    tick();
  endtask

  task automatic xmit(logic [2:0] s);
    idle(); pix_xmit = 1; scale_sel = s; tick(); idle();
  endtask

  task automatic drain();
    idle(); out_ready = 1;
    for (int i = 0; i < DEPTH + 2; i++) tick();
    out_ready = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state, then a transmit stores zero
    tag = "R1";
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    check("R1 ovf_flag after reset", 32'(ovf_flag), 32'd0);
    xmit(3'd0);
    check("R1 first word zero", 32'(out_data), 32'd0);
    drain();

    // R2 R3 R5: one pixel, reference added, signal subtracted
    tag = "R2";
    take(1, 12'd1000, 1);
    for (int i = 0; i < 4; i++) take(1, 12'd1000 + 12'(i), 0);
    tag = "R5";
    idle(); pix_xmit = 1; scale_sel = 0; smp_valid = 1; acc_take = 1; acc_add = 0; smp_data = 12'd100;
    tick(); idle();
    check("R5 word uses sum before update", 32'(out_data), 32'd5006);
    for (int i = 0; i < 4; i++) take(0, 12'd400, 0);
    xmit(3'd0);
    drain();
    tag = "R3";
    take(0, 12'd7, 1);
    xmit(3'd0);
    check("R3 clear with take keeps only that sample", 32'(out_data), 32'h0000fff9);
    drain();

    // R6: saturation and shift clamp
    tag = "R6";
    take(1, 12'd4095, 1);
    for (int i = 0; i < 99; i++) take(1, 12'd4095, 0);
    xmit(3'd0);
    check("R6 positive saturation", 32'(out_data), 32'd32767);
    xmit(3'd4); xmit(3'd7); xmit(3'd2);
    drain();
    take(0, 12'd4095, 1);
    for (int i = 0; i < 99; i++) take(0, 12'd4095, 0);
    xmit(3'd0);
    check("R6 negative saturation", 32'(out_data), 32'h00008000);
    xmit(3'd5);
    drain();
    // R2: wrap modulo 2^20
    for (int i = 0; i < 200; i++) take(0, 12'd4095, 0);
    xmit(3'd4);
    drain();

    // R4: samples without take or without valid are ignored
    tag = "R4";
    take(1, 12'd50, 1);
    idle(); smp_valid = 1; smp_data = 12'd999; acc_take = 0; tick();
    idle(); smp_valid = 0; acc_take = 1; smp_data = 12'd999; tick();
    xmit(3'd0);
    check("R4 ignored samples", 32'(out_data), 32'd50);
    drain();

    // R7: raw mode, transmit strobes have no effect
    tag = "R7";
    raw_mode = 1;
    idle(); smp_valid = 1; smp_data = 12'hABC; tick();
    check("R7 raw zero-extended", 32'(out_data), 32'h00000ABC);
    idle(); pix_xmit = 1; tick();
    idle(); smp_valid = 1; smp_data = 12'hFFF; tick();
    out_ready = 1; idle(); tick();
    check("R7 xmit ignored, next is raw", 32'(out_data), 32'h00000FFF);
    drain();
    raw_mode = 0;

    // R9 R10: overflow handling
    tag = "R9";
    for (int i = 0; i < DEPTH + 1; i++) xmit(3'd0);
    check("R9 ovf after drop", 32'(ovf_flag), 32'd1);
    tag = "R10";
    idle(); ovf_clr = 1; pix_xmit = 1; tick();
    check("R10 set wins over clear", 32'(ovf_flag), 32'd1);
    idle(); ovf_clr = 1; tick();
    check("R10 cleared", 32'(ovf_flag), 32'd0);
    tag = "R9";
    idle(); pix_xmit = 1; out_ready = 1; tick();
    check("R9 pop does not make room", 32'(ovf_flag), 32'd1);
    idle(); ovf_clr = 1; tick();
    drain();

    // R8: random traffic with back-pressure
    tag = "R8";
    for (int i = 0; i < 6000; i++) begin
      idle();
      if (i % 500 == 0) raw_mode = ($urandom_range(0, 3) == 0);
      smp_valid = ($urandom_range(0, 9) < 8);
      smp_data  = 12'($urandom);
      acc_take  = ($urandom_range(0, 9) < 7);
      acc_add   = $urandom_range(0, 1);
      acc_clear = ($urandom_range(0, 19) == 0);
      pix_xmit  = ($urandom_range(0, 9) == 0);
      scale_sel = 3'($urandom);
      out_ready = ($urandom_range(0, 9) < 6);
      ovf_clr   = ($urandom_range(0, 19) == 0);
      tick();
    end
    raw_mode = 0;
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule